// File: doc/BRIEF.md
# Ternary Adder Chain with Half-Cluster Segments

This block adds three 20-bit operands in one pass. The adder is built from ten logic cells, and each cell holds two bit slices. Every slice first forms the parity and the majority of its three operand bits, so the operands are reduced to carry-save form. The majority bit goes to the adder of the next slice over a dedicated side link. A conventional ripple carry then adds the parity vector to the forwarded majority vector. Two cascade inputs and two cascade outputs let a wider adder continue into the next cluster of cells.

A two-bit segment select sets how much of the cluster the adder uses. The adder can span all ten cells. It can instead use only the lower five cells (bits 9..0) or only the upper five cells (bits 19..10). Each half-cluster segment takes the cascade inputs at its own first slice and drives the cascade outputs from its own last slice. A fourth setting idles the whole chain. The operand bits of any unused half are forced low before the adder logic, and the sum bits of that half read zero. Results are registered, so they appear one clock after the operands.

Top module: `ternary_adder_chain`

## Requirements
- R1: With seg_sel = 2'b00 (whole cluster), one clock after the inputs: sum_o + 2^20*carry_o + 2^20*shared_o equals op_a + op_b + op_c + chain_cy_in + chain_sh_in. The two chain inputs count only while cascade_en is high.
- R2: In every active segment, shared_o equals the majority of the three operand bits at the most significant slice of that segment (bit 19 for the whole cluster and the upper half, bit 9 for the lower half).
- R3: While cascade_en is low, chain_cy_in and chain_sh_in have no effect on sum_o, carry_o or shared_o.
- R4: With seg_sel = 2'b01 (lower half only), sum_o[9:0] + 1024*(carry_o + shared_o) equals op_a[9:0] + op_b[9:0] + op_c[9:0] plus the enabled chain inputs.
- R5: With seg_sel = 2'b10 (upper half only), sum_o[19:10] + 1024*(carry_o + shared_o) equals op_a[19:10] + op_b[19:10] + op_c[19:10] plus the enabled chain inputs. The chain inputs enter at bit 10.
- R6: In a half segment, the operand bits of the other half are ignored, and the sum bits of the other half are zero.
- R7: With seg_sel = 2'b11 (idle), sum_o, carry_o and shared_o are all zero one clock later.
- R8: While rst_n is low, sum_o, carry_o and shared_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_sel | input | 2 | Segment select: 00 whole, 01 lower half, 10 upper half, 11 idle |
| cascade_en | input | 1 | Accept the chain inputs |
| chain_cy_in | input | 1 | Ripple carry from the previous cluster |
| chain_sh_in | input | 1 | Majority link from the previous cluster |
| op_a | input | 20 | First operand |
| op_b | input | 20 | Second operand |
| op_c | input | 20 | Third operand |
| sum_o | output | 20 | Registered sum |
| carry_o | output | 1 | Ripple carry out of the last active slice |
| shared_o | output | 1 | Majority link out of the last active slice |

## Verification
The bench goes after the cases where both chains saturate at the same time. With all operands at all ones and both chain inputs set, an adder that drops the majority link at a cell boundary loses a power of two, and one that joins the two carries out into a single output gives a wrong weight. In the half modes, the bench puts noise on the unused half. A segment boundary that still leaks the lower half's carries into bit 10 then shows nonzero upper sum bits, or an upper-half total that is off by the leaked carry. A design that takes the cascade inputs without checking the enable fails when the bench toggles them with cascade_en low.

// File: rtl/tac_pkg.sv
package tac_pkg;
   typedef enum logic [1:0] {
      TAC_FULL = 2'b00,
      TAC_LOW  = 2'b01,
      TAC_HIGH = 2'b10,
      TAC_IDLE = 2'b11
   } tac_seg_e;
endpackage

// File: rtl/tac_slice.sv
// One bit slice: carry-save compression of three bits, then a full adder
// that folds in the majority bit of the previous slice and the ripple carry.
module tac_slice (
   input  logic x_a,
   input  logic x_b,
   input  logic x_c,
   input  logic sh_in,
   input  logic cy_in,
   output logic sum,
   output logic sh_out,
   output logic cy_out
);
   logic par;
   always_comb begin
      par    = x_a ^ x_b ^ x_c;
      sh_out = (x_a & x_b) | (x_a & x_c) | (x_b & x_c);
      {cy_out, sum} = {1'b0, par} + {1'b0, sh_in} + {1'b0, cy_in};
   end
endmodule

// File: rtl/tac_cell.sv
// One logic cell: SPC slices wired in sequence on both chains.
module tac_cell #(
   parameter int SPC = 2
) (
   input  logic [SPC-1:0] x_a,
   input  logic [SPC-1:0] x_b,
   input  logic [SPC-1:0] x_c,
   input  logic           sh_in,
   input  logic           cy_in,
   output logic [SPC-1:0] sum,
   output logic           sh_out,
   output logic           cy_out
);
   logic [SPC:0] sh_w;
   logic [SPC:0] cy_w;
   assign sh_w[0] = sh_in;
   assign cy_w[0] = cy_in;

   for (genvar s = 0; s < SPC; s++) begin : g_slice
      tac_slice u_slice (
         .x_a   (x_a[s]),
         .x_b   (x_b[s]),
         .x_c   (x_c[s]),
         .sh_in (sh_w[s]),
         .cy_in (cy_w[s]),
         .sum   (sum[s]),
         .sh_out(sh_w[s+1]),
         .cy_out(cy_w[s+1])
      );
   end

   assign sh_out = sh_w[SPC];
   assign cy_out = cy_w[SPC];
endmodule

// File: rtl/tac_opgate.sv
// Forces the operand bits of a disabled half to zero.
module tac_opgate #(
   parameter int W  = 20,
   parameter int HW = 10
) (
   input  logic [W-1:0] d_in,
   input  logic         lo_en,
   input  logic         hi_en,
   output logic [W-1:0] d_out
);
   assign d_out = {d_in[W-1:HW] & {(W-HW){hi_en}}, d_in[HW-1:0] & {HW{lo_en}}};
endmodule

// File: rtl/ternary_adder_chain.sv
module ternary_adder_chain
   import tac_pkg::*;
#(
   parameter int CELLS = 10,
   parameter int SPC   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           seg_sel,
   input  logic                 cascade_en,
   input  logic                 chain_cy_in,
   input  logic                 chain_sh_in,
   input  logic [CELLS*SPC-1:0] op_a,
   input  logic [CELLS*SPC-1:0] op_b,
   input  logic [CELLS*SPC-1:0] op_c,
   output logic [CELLS*SPC-1:0] sum_o,
   output logic                 carry_o,
   output logic                 shared_o
);
   localparam int W      = CELLS * SPC;
   localparam int HCELLS = CELLS / 2;
   localparam int HW     = HCELLS * SPC;
   localparam int TW     = W + 2;

   if (CELLS < 2 || (CELLS % 2) != 0) begin : g_bad_cells
      $error("CELLS must be even and at least 2");
   end
   if (SPC < 1) begin : g_bad_spc
      $error("SPC must be at least 1");
   end

   tac_seg_e seg;
   logic     lo_en, hi_en, cas_cy, cas_sh;
   assign seg    = tac_seg_e'(seg_sel);
   assign lo_en  = (seg == TAC_FULL) || (seg == TAC_LOW);
   assign hi_en  = (seg == TAC_FULL) || (seg == TAC_HIGH);
   assign cas_cy = cascade_en & chain_cy_in;
   assign cas_sh = cascade_en & chain_sh_in;

   logic [W-1:0] ga, gb, gc;
   tac_opgate #(.W(W), .HW(HW)) u_gate_a (.d_in(op_a), .lo_en(lo_en), .hi_en(hi_en), .d_out(ga));
   tac_opgate #(.W(W), .HW(HW)) u_gate_b (.d_in(op_b), .lo_en(lo_en), .hi_en(hi_en), .d_out(gb));
   tac_opgate #(.W(W), .HW(HW)) u_gate_c (.d_in(op_c), .lo_en(lo_en), .hi_en(hi_en), .d_out(gc));

   logic [CELLS:0]   sh_out_w, cy_out_w;
   logic [CELLS-1:0] sh_in_w, cy_in_w;
   logic [W-1:0]     raw_sum;

   for (genvar j = 0; j < CELLS; j++) begin : g_cell
      if (j == 0) begin : g_entry_low
         assign sh_in_w[j] = lo_en & cas_sh;
         assign cy_in_w[j] = lo_en & cas_cy;
      end else if (j == HCELLS) begin : g_entry_high
         assign sh_in_w[j] = (seg == TAC_HIGH) ? cas_sh :
                             (seg == TAC_FULL) ? sh_out_w[j] : 1'b0;
         assign cy_in_w[j] = (seg == TAC_HIGH) ? cas_cy :
                             (seg == TAC_FULL) ? cy_out_w[j] : 1'b0;
      end else begin : g_link
         assign sh_in_w[j] = sh_out_w[j];
         assign cy_in_w[j] = cy_out_w[j];
      end

      tac_cell #(.SPC(SPC)) u_cell (
         .x_a   (ga[j*SPC +: SPC]),
         .x_b   (gb[j*SPC +: SPC]),
         .x_c   (gc[j*SPC +: SPC]),
         .sh_in (sh_in_w[j]),
         .cy_in (cy_in_w[j]),
         .sum   (raw_sum[j*SPC +: SPC]),
         .sh_out(sh_out_w[j+1]),
         .cy_out(cy_out_w[j+1])
      );
   end
   assign sh_out_w[0] = 1'b0;
   assign cy_out_w[0] = 1'b0;

   logic [W-1:0] sum_nxt;
   logic         cy_nxt, sh_nxt;
   always_comb begin
      sum_nxt = {raw_sum[W-1:HW] & {(W-HW){hi_en}}, raw_sum[HW-1:0] & {HW{lo_en}}};
      unique case (seg)
         TAC_LOW:              begin cy_nxt = cy_out_w[HCELLS]; sh_nxt = sh_out_w[HCELLS]; end
         TAC_FULL, TAC_HIGH:   begin cy_nxt = cy_out_w[CELLS];  sh_nxt = sh_out_w[CELLS];  end
         default:              begin cy_nxt = 1'b0;             sh_nxt = 1'b0;             end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o    <= '0;
         carry_o  <= 1'b0;
         shared_o <= 1'b0;
      end else begin
         sum_o    <= sum_nxt;
         carry_o  <= cy_nxt;
         shared_o <= sh_nxt;
      end
   end

   AST_FULL_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_sel == 2'b00) |=>
         (TW'(sum_o) + (TW'(carry_o) << W) + (TW'(shared_o) << W)) ==
         $past(TW'(op_a) + TW'(op_b) + TW'(op_c) + TW'(cascade_en & chain_cy_in)
               + TW'(cascade_en & chain_sh_in))); // R1

   AST_SHARED_MAJ: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_sel == 2'b00) |=>
         shared_o == $past((op_a[W-1] & op_b[W-1]) | (op_a[W-1] & op_c[W-1]) |
                           (op_b[W-1] & op_c[W-1]))); // R2

   AST_LOW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_sel == 2'b01) |=> (sum_o[W-1:HW] == '0)); // R6

   AST_HIGH_LOWER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_sel == 2'b10) |=> (sum_o[HW-1:0] == '0)); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_sel == 2'b11) |=> (sum_o == '0 && !carry_o && !shared_o)); // R7
endmodule

// File: tb/test_ternary_adder_chain.sv
module test_ternary_adder_chain;
   localparam int W  = 20;
   localparam int HW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    seg_sel = 2'b00;
   logic          cascade_en = 1'b0, chain_cy_in = 1'b0, chain_sh_in = 1'b0;
   logic [W-1:0]  op_a = '0, op_b = '0, op_c = '0;
   logic [W-1:0]  sum_o;
   logic          carry_o, shared_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ternary_adder_chain i_ternary_adder_chain (
      .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel), .cascade_en(cascade_en),
      .chain_cy_in(chain_cy_in), .chain_sh_in(chain_sh_in),
      .op_a(op_a), .op_b(op_b), .op_c(op_c),
      .sum_o(sum_o), .carry_o(carry_o), .shared_o(shared_o)
   );

   // Expected {shared, carry, sum} from the requirement equations.
   function automatic logic [W+1:0] model(input logic [1:0] m, input logic [W-1:0] a,
         input logic [W-1:0] b, input logic [W-1:0] c, input logic ce,
         input logic ci, input logic si);
      int lo, n;
      logic [31:0] aa, bb, cc, tot, msk;
      logic mj, co;
      if (m == 2'b11) return '0;
      lo  = (m == 2'b10) ? HW : 0;
      n   = (m == 2'b00) ? W : HW;
      msk = (32'd1 << n) - 1;
      aa  = (32'(a) >> lo) & msk;
      bb  = (32'(b) >> lo) & msk;
      cc  = (32'(c) >> lo) & msk;
      tot = aa + bb + cc + (ce ? 32'(ci) + 32'(si) : 32'd0);
      mj  = (aa[n-1] & bb[n-1]) | (aa[n-1] & cc[n-1]) | (bb[n-1] & cc[n-1]);
      co  = 1'((tot >> n) - 32'(mj));
      return {mj, co, W'((tot & msk) << lo)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] m, input logic [W-1:0] a, input logic [W-1:0] b,
         input logic [W-1:0] c, input logic ce, input logic ci, input logic si);
      logic [W+1:0] e;
      string tag;
      @(negedge clk);
      seg_sel = m; op_a = a; op_b = b; op_c = c;
      cascade_en = ce; chain_cy_in = ci; chain_sh_in = si;
      e = model(m, a, b, c, ce, ci, si);
      @(negedge clk);
      case (m)
         2'b00: tag = "R1";
         2'b01: tag = "R4";
         2'b10: tag = "R5";
         default: tag = "R7";
      endcase
      chk(tag, {10'd0, shared_o, carry_o, sum_o}, {10'd0, e});
      if (m != 2'b11) chk("R2", 32'(shared_o), 32'(e[W+1]));
      if (m == 2'b01) chk("R6", 32'(sum_o[W-1:HW]), 32'd0);
      if (m == 2'b10) chk("R6", 32'(sum_o[HW-1:0]), 32'd0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      op_a = 20'hFFFFF; op_b = 20'hFFFFF; op_c = 20'hFFFFF; cascade_en = 1'b1;
      chain_cy_in = 1'b1; chain_sh_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8", {10'd0, shared_o, carry_o, sum_o}, 32'd0);
      rst_n = 1'b1;

      // Both chains saturated across the whole cluster.
      apply(2'b00, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 1'b1, 1'b1, 1'b1);
      chk("R1", 32'(sum_o), 32'hFFFFF);
      // R3: chain inputs ignored while cascade is disabled.
      apply(2'b00, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 1'b0, 1'b1, 1'b1);
      chk("R3", 32'(sum_o), 32'hFFFFD);
      apply(2'b00, 20'h12345, 20'h0F0F0, 20'h00001, 1'b0, 1'b1, 1'b0);
      chk("R3", 32'(sum_o), 32'(20'h12345 + 20'h0F0F0 + 20'h00001));
      apply(2'b00, 20'h0, 20'h0, 20'h0, 1'b1, 1'b1, 1'b1);
      chk("R1", 32'(sum_o), 32'd2);
      // Half segments with noise on the unused half.
      apply(2'b01, 20'hABFFF, 20'h5_43FF, 20'hFF3FF, 1'b1, 1'b1, 1'b1);
      apply(2'b10, 20'hFFDA5, 20'hFFC3C, 20'hFFE00, 1'b1, 1'b1, 1'b0);
      apply(2'b10, 20'h003FF, 20'h003FF, 20'h003FF, 1'b0, 1'b1, 1'b1);
      chk("R6", {10'd0, shared_o, carry_o, sum_o}, 32'd0);
      apply(2'b11, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 1'b1, 1'b1, 1'b1);

      for (int i = 0; i < 600; i++) begin
         apply(2'($urandom_range(0, 3)), W'($urandom), W'($urandom), W'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom));
      end

      // Reset in mid-run clears the outputs.
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8", {10'd0, shared_o, carry_o, sum_o}, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule